// File: doc/BRIEF.md
# Serial Character Transmitter with Parity Slot Modes

This block turns bytes offered on a valid/ready input into asynchronous serial characters on a single output line. Each character is a low start bit, five to eight data bits sent least significant bit first, an optional extra bit and one high stop bit. Every bit lasts one period of an externally supplied 1x bit tick. The line rests high between characters.

A five-bit mode input controls each character. One field sets the data length. Another selects what goes in the extra bit after the data: a computed parity bit, a fixed value, nothing, or an address/data marker for a multidrop bus. A single shared bit means odd/even, the fixed value, or address/data, depending on that selection. The mode and the data are captured when a byte is accepted, so the surrounding logic may change them while the character is still going out.

Top module: `uart_md_tx`

## Requirements
- R1: After reset, and whenever no character is in progress, `tx_ready` is 1 and `txd` is 1.
- R2: A byte is accepted at a rising clock edge where `tx_valid` and `tx_ready` are both 1. From the next cycle `tx_ready` is 0. `txd` stays 1 until the first clock edge with `bit_tick` high after acceptance. At that edge the start bit (0) begins.
- R3: Data length is set by `mode_cfg[1:0]`: 00 selects 5 bits, 01 selects 6, 10 selects 7 and 11 selects 8. The low data bits of `tx_data` follow the start bit, least significant first, one bit per tick period.
- R4: With `mode_cfg[4:3]`=00 (parity), the slot after the data holds even parity over the sent data bits when `mode_cfg[2]`=0, and odd parity when it is 1.
- R5: With `mode_cfg[4:3]`=01 (forced), the slot after the data holds the value of `mode_cfg[2]`.
- R6: With `mode_cfg[4:3]`=10 (none), no slot is sent, and the stop bit follows the last data bit directly.
- R7: With `mode_cfg[4:3]`=11 (multidrop), the slot after the data holds the address/data flag `mode_cfg[2]` (1 for address, 0 for data).
- R8: The stop bit is 1 and lasts one tick period. `tx_ready` returns to 1 in the cycle after the tick edge that ends it.
- R9: Changes to `mode_cfg` or `tx_data` after acceptance have no effect on the character in progress. `txd` changes only at clock edges where `bit_tick` is high.
- R10: `tx_valid` is ignored while `tx_ready` is 0. No second character is taken or framed until the current one has finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_tick | input | 1 | One-cycle pulse marking each bit period |
| mode_cfg | input | 5 | [1:0] length, [2] odd/forced/address bit, [4:3] slot mode |
| tx_valid | input | 1 | Byte offered |
| tx_data | input | 8 | Byte to send |
| tx_ready | output | 1 | Transmitter can take a byte |
| txd | output | 1 | Serial line, idles high |

## Verification
`tx_ready` falls in the cycle after the acceptance edge. Every bit of the frame appears in the cycle after the tick edge that starts it, with one register between the tick and the line. The bench therefore waits for the tick and lets that edge pass. It then reads `txd` half a cycle later, at the falling edge, and checks each bit against a value computed from the length, the slot mode and the data. After the tick that ends the stop bit, the bench checks `tx_ready` and the idle line at the next falling edge. It sweeps every length, slot mode and shared-bit value over several data patterns. While each character is going out, it scrambles the inputs and holds `tx_valid` high.

// File: rtl/uart_md_tx.sv
module uart_md_tx #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_tick,
  input  logic [4:0]    mode_cfg,
  input  logic          tx_valid,
  input  logic [DW-1:0] tx_data,
  output logic          tx_ready,
  output logic          txd
);
  localparam int IW = $clog2(DW);

  typedef enum logic [2:0] {S_IDLE, S_WAIT, S_START, S_DATA, S_SLOT, S_STOP} st_t;

  st_t           st;
  logic [DW-1:0] shreg;
  logic [IW-1:0] idx, last_idx;
  logic          slot_en, slot_bit, txd_q;
  logic [DW-1:0] masked;
  logic          slot_calc;

  wire accept = tx_valid && tx_ready;

  assign tx_ready = (st == S_IDLE);
  assign txd      = txd_q;
  assign masked   = tx_data & ({DW{1'b1}} >> (2'd3 - mode_cfg[1:0]));

  always_comb begin
    case (mode_cfg[4:3])
      2'b00:   slot_calc = (^masked) ^ mode_cfg[2];
      default: slot_calc = mode_cfg[2];
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      txd_q    <= 1'b1;
      shreg    <= '0;
      idx      <= '0;
      last_idx <= '0;
      slot_en  <= 1'b0;
      slot_bit <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (accept) begin
          shreg    <= masked;
          last_idx <= IW'(3'd4 + {1'b0, mode_cfg[1:0]});
          slot_en  <= (mode_cfg[4:3] != 2'b10);
          slot_bit <= slot_calc;
          st       <= S_WAIT;
        end
        S_WAIT: if (bit_tick) begin
          txd_q <= 1'b0;
          st    <= S_START;
        end
        S_START: if (bit_tick) begin
          txd_q <= shreg[0];
          shreg <= shreg >> 1;
          idx   <= '0;
          st    <= S_DATA;
        end
        S_DATA: if (bit_tick) begin
          if (idx == last_idx) begin
            txd_q <= slot_en ? slot_bit : 1'b1;
            st    <= slot_en ? S_SLOT : S_STOP;
          end else begin
            txd_q <= shreg[0];
            shreg <= shreg >> 1;
            idx   <= idx + 1'b1;
          end
        end
        S_SLOT: if (bit_tick) begin
          txd_q <= 1'b1;
          st    <= S_STOP;
        end
        S_STOP: if (bit_tick) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> txd);
  p_busy_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !tx_ready);
  p_start_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(txd) |-> $past(bit_tick));
  p_hold_between_ticks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_tick && !tx_ready) |=> $stable(txd));
  p_release_after_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_ready) |-> ($past(txd) && $past(bit_tick)));
  p_no_accept_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_ready && !bit_tick) |=> !tx_ready);
endmodule

// File: tb/test_uart_md_tx.sv
module test_uart_md_tx;
  logic       clk = 0, rst_n = 0, bit_tick = 0, tx_valid = 0;
  logic [4:0] mode_cfg = 0;
  logic [7:0] tx_data = 0;
  logic       tx_ready, txd;
  int checks = 0, errors = 0;
  int tcnt = 0;

  uart_md_tx i_uart_md_tx (.clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .mode_cfg(mode_cfg),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready), .txd(txd));

  always #5 clk = ~clk;

  always @(negedge clk) begin
    tcnt = (tcnt + 1) % 4;
    bit_tick <= (tcnt == 0);
  end

  task automatic chk(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic step_bit();
    while (!bit_tick) begin @(negedge clk); #1; end
    @(negedge clk); #1;
  endtask

  task automatic send(input logic [7:0] d, input logic [4:0] m);
    int n;
    logic p;
    logic [7:0] md;
    n  = 5 + int'(m[1:0]);
    md = d & 8'((1 << n) - 1);
    @(negedge clk); #1;
    tx_valid = 1; tx_data = d; mode_cfg = m;
    chk(tx_ready, 1'b1, "R1");
    @(negedge clk); #1;
    chk(tx_ready, 1'b0, "R2");
    chk(txd, 1'b1, "R2");
    mode_cfg = ~m; tx_data = ~d;
    step_bit();
    chk(txd, 1'b0, "R2");
    for (int i = 0; i < n; i++) begin
      step_bit();
      chk(txd, md[i], "R3");
    end
    case (m[4:3])
      2'b00: begin step_bit(); p = (^md) ^ m[2]; chk(txd, p, "R4"); end
      2'b01: begin step_bit(); chk(txd, m[2], "R5"); end
      2'b11: begin step_bit(); chk(txd, m[2], "R7"); end
      default: ;
    endcase
    step_bit();
    chk(txd, 1'b1, m[4:3] == 2'b10 ? "R6" : "R8");
    chk(tx_ready, 1'b0, "R10");
    tx_valid = 0;
    step_bit();
    chk(tx_ready, 1'b1, "R8");
    chk(txd, 1'b1, "R9");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] pats [4];
    pats[0] = 8'hA5; pats[1] = 8'h3C; pats[2] = 8'hFF; pats[3] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    chk(tx_ready, 1'b1, "R1");
    chk(txd, 1'b1, "R1");
    for (int pm = 0; pm < 4; pm++)
      for (int ln = 0; ln < 4; ln++)
        for (int fb = 0; fb < 2; fb++)
          for (int k = 0; k < 4; k++)
            send(pats[k], {2'(pm), 1'(fb), 2'(ln)});
    send(8'h81, 5'b00_1_11);
    send(8'h7E, 5'b11_1_00);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule